// File: doc/BRIEF.md
# Sixteen-Bit Compare Register Byte Bridge

This block sits between an 8-bit processor bus and a 16-bit compare register whose full value is compared against a counter on every cycle. A value that is only half updated must never reach that comparator. The bridge therefore keeps one shared temporary byte.

A write to the high-byte address only parks the bus byte in the temporary byte. A write to the low-byte address then issues a single-cycle 16-bit write strobe. That strobe carries the bus byte in bits 7:0 and the temporary byte in bits 15:8. It goes to the compare buffer when double buffering is enabled, and to the active compare register otherwise.

Reads bypass the temporary byte. The selected byte of the register that software can see comes back combinationally: the buffer when double buffering is on, the active register when it is off. The storage for the target registers is outside the bridge and is fed back to it for reads.

Top module: `cmp16_byte_bridge`

## Requirements
- R1: After reset the temporary byte is zero, so a low-byte write issued before any high-byte write commits 0x00 in bits 15:8.
- R2: A write to the high-byte address (HI_ADDR, default 0x27) raises no write strobe. It loads the bus byte into the temporary byte at that clock edge.
- R3: A write to the low-byte address (LO_ADDR, default 0x26) raises exactly one write strobe in the same cycle. The strobe carries {temporary byte, bus byte} on `cmp_wdata`.
- R4: The low-byte write strobe is `cmp_we_buf` when `dbuf_en` is 1 and `cmp_we_act` when `dbuf_en` is 0.
- R5: A second low-byte write without an intervening high-byte write reuses the temporary byte left by the last high-byte write.
- R6: A read returns the visible register combinationally. That register is `cmp_buf_q` when `dbuf_en` is 1 and `cmp_act_q` otherwise. The high address returns bits 15:8 and the low address returns bits 7:0. `bus_rdata` is zero when no read is active or the address decodes to neither byte.
- R7: Reads have no side effect: the temporary byte is unchanged by any read.
- R8: Writes to any other address raise no strobe and leave the temporary byte unchanged.
- R9: The two write strobes are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Single-cycle write strobe from the bus |
| bus_rd | input | 1 | Read enable from the bus |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte |
| dbuf_en | input | 1 | Double buffering enabled: the buffer is the write target and the visible register |
| cmp_buf_q | input | 16 | Current compare buffer contents |
| cmp_act_q | input | 16 | Current active compare register contents |
| cmp_we_buf | output | 1 | 16-bit write strobe to the compare buffer |
| cmp_we_act | output | 1 | 16-bit write strobe to the active compare register |
| cmp_wdata | output | 16 | 16-bit value to commit |

## Verification
The bench targets these corner cases:
- A low-byte write straight after reset. A bridge with an unreset or wrong initial temporary byte would commit garbage in the upper half.
- Repeated low-byte writes with no high-byte write between them. A design that clears or consumes the temporary byte after a commit would lose the upper half on the second write.
- Reads and writes to foreign addresses placed between the high and low writes. A design that shares the temporary byte with the read path, or decodes addresses loosely, would corrupt the later commit.
- Toggling `dbuf_en`. A wrong target select would strobe the wrong register or read back the wrong one.
- High-byte writes alone. A design that commits on them would show a half-updated value.

// File: rtl/cmp16_bridge_pkg.sv
package cmp16_bridge_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2
  } byte_sel_e;

  function automatic logic [15:0] join_bytes(input logic [7:0] hi, input logic [7:0] lo);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/cmp16_addr_decode.sv
module cmp16_addr_decode
  import cmp16_bridge_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter logic [ADDR_W-1:0] LO_ADDR = 6'h26,
  parameter logic [ADDR_W-1:0] HI_ADDR = 6'h27
) (
  input  logic [ADDR_W-1:0] addr,
  output byte_sel_e         sel
);
  always_comb begin
    if (addr == HI_ADDR)      sel = SEL_HI;
    else if (addr == LO_ADDR) sel = SEL_LO;
    else                      sel = SEL_NONE;
  end
endmodule

// File: rtl/cmp16_temp_byte.sv
module cmp16_temp_byte #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end

  p_temp_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> q == $past(din));
  p_temp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));
endmodule

// File: rtl/cmp16_read_mux.sv
module cmp16_read_mux
  import cmp16_bridge_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int REG_W = 2 * DATA_W
) (
  input  logic              rd,
  input  byte_sel_e         sel,
  input  logic              dbuf_en,
  input  logic [REG_W-1:0]  buf_q,
  input  logic [REG_W-1:0]  act_q,
  output logic [DATA_W-1:0] rdata
);
  logic [REG_W-1:0] visible;
  assign visible = dbuf_en ? buf_q : act_q;

  always_comb begin
    rdata = '0;
    if (rd) begin
      case (sel)
        SEL_HI:  rdata = visible[REG_W-1:DATA_W];
        SEL_LO:  rdata = visible[DATA_W-1:0];
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/cmp16_byte_bridge.sv
module cmp16_byte_bridge
  import cmp16_bridge_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] LO_ADDR = 6'h26,
  parameter logic [ADDR_W-1:0] HI_ADDR = 6'h27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              dbuf_en,
  input  logic [15:0]       cmp_buf_q,
  input  logic [15:0]       cmp_act_q,
  output logic              cmp_we_buf,
  output logic              cmp_we_act,
  output logic [15:0]       cmp_wdata
);
  byte_sel_e  sel;
  logic       hi_wr_ev;
  logic       lo_wr_ev;
  logic [7:0] temp_q;

  cmp16_addr_decode #(.ADDR_W(ADDR_W), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)) u_dec (
    .addr(bus_addr), .sel(sel));

  assign hi_wr_ev = bus_wr && (sel == SEL_HI);
  assign lo_wr_ev = bus_wr && (sel == SEL_LO);

  cmp16_temp_byte #(.DATA_W(8)) u_temp (
    .clk(clk), .rst_n(rst_n), .load(hi_wr_ev), .din(bus_wdata), .q(temp_q));

  assign cmp_wdata  = join_bytes(temp_q, bus_wdata);
  assign cmp_we_buf = lo_wr_ev && dbuf_en;
  assign cmp_we_act = lo_wr_ev && !dbuf_en;

  cmp16_read_mux #(.DATA_W(8)) u_rd (
    .rd(bus_rd), .sel(sel), .dbuf_en(dbuf_en),
    .buf_q(cmp_buf_q), .act_q(cmp_act_q), .rdata(bus_rdata));

  p_hi_no_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hi_wr_ev |-> !(cmp_we_buf || cmp_we_act));
  p_one_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmp_we_buf, cmp_we_act}));
  p_commit_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_we_buf || cmp_we_act) |-> cmp_wdata[15:8] == temp_q);
  p_read_no_effect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr) |=> $stable(temp_q));
endmodule

// File: tb/cmp16_byte_bridge_tb.sv
module cmp16_byte_bridge_tb;
  localparam logic [5:0] LO = 6'h26;
  localparam logic [5:0] HI = 6'h27;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0, bus_rd = 0, dbuf_en = 0;
  logic [5:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic [15:0] buf_r = 0, act_r = 0, cmp_wdata;
  logic cmp_we_buf, cmp_we_act;

  int checks = 0, fails = 0;
  logic [7:0] m_temp = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cmp16_byte_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dbuf_en(dbuf_en), .cmp_buf_q(buf_r), .cmp_act_q(act_r),
    .cmp_we_buf(cmp_we_buf), .cmp_we_act(cmp_we_act), .cmp_wdata(cmp_wdata));

  // target register models
  always_ff @(posedge clk) begin
    if (cmp_we_buf) buf_r <= cmp_wdata;
    if (cmp_we_act) act_r <= cmp_wdata;
  end

  function automatic logic [7:0] exp_read(logic [5:0] a, logic db, logic [15:0] b, logic [15:0] c);
    logic [15:0] v = db ? b : c;
    if (a == HI) return v[15:8];
    if (a == LO) return v[7:0];
    return 8'h00;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d, string req);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    #1;
    if (a == LO) begin
      chk(req, {cmp_we_buf, cmp_we_act}, {dbuf_en, !dbuf_en});
      chk(req, cmp_wdata, {m_temp, d});
    end else begin
      chk(a == HI ? "R2" : "R8", {cmp_we_buf, cmp_we_act}, 2'b00);
    end
    if (cmp_we_buf && cmp_we_act) chk("R9", 1, 0);
    @(posedge clk);
    if (a == HI) m_temp = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [5:0] a, string req);
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    #1;
    chk(req, bus_rdata, exp_read(a, dbuf_en, buf_r, act_r));
    @(negedge clk);
    bus_rd = 0;
    #1;
    chk("R6", bus_rdata, 8'h00);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1; chk("R3 idle", {cmp_we_buf, cmp_we_act}, 2'b00);
    // R1: low write after reset commits zero upper byte
    wr(LO, 8'h5A, "R1");
    rd(LO, "R6"); rd(HI, "R6");
    // R2/R3: normal sequence into active register
    wr(HI, 8'hC3, "R2");
    wr(LO, 8'h11, "R3");
    // R5: repeated low write reuses temp
    wr(LO, 8'h22, "R5");
    // R4: buffer target
    dbuf_en = 1;
    wr(HI, 8'hAB, "R2");
    wr(LO, 8'hCD, "R4");
    rd(HI, "R6"); rd(LO, "R6");
    // R7: reads between high and low do not disturb temp
    wr(HI, 8'h77, "R2");
    rd(HI, "R7"); rd(LO, "R7"); rd(6'h05, "R7");
    wr(LO, 8'h01, "R7");
    // R8: foreign writes ignored
    wr(HI, 8'h3C, "R2");
    wr(6'h25, 8'hFF, "R8");
    wr(6'h28, 8'hEE, "R8");
    wr(LO, 8'h02, "R8");
    dbuf_en = 0;
    rd(HI, "R6");
    // random mix
    for (int i = 0; i < 400; i++) begin
      int k = $urandom_range(0, 9);
      if (k == 0) begin @(negedge clk); dbuf_en = $urandom_range(0, 1); end
      else if (k < 4) wr(HI, 8'($urandom), "R2");
      else if (k < 7) wr(LO, 8'($urandom), "R3");
      else if (k == 7) wr(6'($urandom), 8'($urandom), "R8");
      else rd($urandom_range(0, 1) ? HI : LO, "R6");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule